// File: doc/BRIEF.md
# Redundant Radix-2 Digit Adder

This block adds two redundant radix-2 numbers. Each digit takes a value of 0, 1 or 2 and travels on two wires, and the result comes back in exactly the same digit format. A result can therefore be fed straight back as an operand, which suits loops that add repeatedly, such as iterative multiply and divide. The block is purely combinational, has no clock, and holds no state.

Every digit position is built from three levels. The first level folds the two incoming redundant digits into one redundant digit and one binary transfer toward the next position. The other two levels add that redundant digit to the transfer arriving from below. They produce a binary sum bit and a second binary transfer upward. A result digit is the pair (sum bit of this position, second transfer from the position below). Because of this, a change in an operand digit reaches at most two positions above it, and no carry ripples across the word.

Operands carry `N` digits. The result carries `N+2` digits, so every possible sum fits.

Top module: `rcsa_adder`

## Requirements
- R1: Digit k of a bus occupies bits [2k+1:2k]. Its value is the number of set bits in the pair: 00=0, 01=1, 10=1, 11=2. Either code for 1 is accepted on the operands and gives the same result value.
- R2: For all operand values, the value of `sum_o` (the sum over k of digit value times 2^k) equals the value of `a_i` plus the value of `b_i`.
- R3: `sum_o` has N+2 digits, and its most significant digit is always code 00.
- R4: Changing operand digit j alters no result digit below position j or above position j+2. In particular, result digit 0 is at most 1 and has the parity of the sum of the two operand digits 0.
- R5: When both operands have every digit equal to 2 (code 11), the result value is 2^(N+2) - 4.
- R6: When both operands are zero, every bit of `sum_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 2*N | First redundant operand, N two-bit digits |
| b_i | input | 2*N | Second redundant operand, N two-bit digits |
| sum_o | output | 2*(N+2) | Redundant sum, N+2 two-bit digits |

## Verification
The bench drives the same operand values once with 01 and once with 10 for every digit of value 1, and confirms that the sum does not move. A fold level that weighted the two bits of a digit differently would give two distinct results here. All-2 operands push the largest possible sum into the two guard digits: an array without the guard digits, or one that dropped the top transfers, would lose 2^N or more. Single-digit perturbations at several positions confirm the three-position window. A transfer routed to the wrong position would change a result digit outside that window, even when the total stayed right. Random operands and the zero case round this out against the integer model.

// File: rtl/rcsa_pkg.sv
package rcsa_pkg;

    localparam int DIGIT_BITS   = 2;
    localparam int GUARD_DIGITS = 2;

    // Two-wire digit: value is hi + lo.
    typedef struct packed {
        logic hi;
        logic lo;
    } rdigit_t;

    typedef struct packed {
        logic carry;
        logic sum;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic x, input logic y, input logic z);
        fa_out_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

endpackage

// File: rtl/rcsa_fold.sv
// Level one: two redundant digits -> one redundant digit + transfer up.
module rcsa_fold
    import rcsa_pkg::*;
(
    input  rdigit_t a_dig,
    input  rdigit_t b_dig,
    output rdigit_t part_o,
    output logic    xfer_o
);
    fa_out_t fa;

    always_comb begin
        fa          = full_add(a_dig.hi, a_dig.lo, b_dig.hi);
        part_o.hi   = fa.sum;
        part_o.lo   = b_dig.lo;
        xfer_o      = fa.carry;
    end
endmodule

// File: rtl/rcsa_merge.sv
// Levels two and three: redundant digit + binary transfer -> sum bit + transfer up.
module rcsa_merge
    import rcsa_pkg::*;
(
    input  rdigit_t part_i,
    input  logic    xfer_i,
    output logic    sum_bit_o,
    output logic    xfer_o
);
    fa_out_t fa;

    always_comb begin
        fa        = full_add(part_i.hi, part_i.lo, xfer_i);
        sum_bit_o = fa.sum;
        xfer_o    = fa.carry;
    end
endmodule

// File: rtl/rcsa_cell.sv
module rcsa_cell
    import rcsa_pkg::*;
(
    input  rdigit_t a_dig,
    input  rdigit_t b_dig,
    input  logic    fold_ci,
    input  logic    merge_ci,
    output logic    fold_co,
    output logic    merge_co,
    output rdigit_t res_o
);
    rdigit_t part;
    logic    sum_bit;

    rcsa_fold u_fold (
        .a_dig  (a_dig),
        .b_dig  (b_dig),
        .part_o (part),
        .xfer_o (fold_co)
    );

    rcsa_merge u_merge (
        .part_i    (part),
        .xfer_i    (fold_ci),
        .sum_bit_o (sum_bit),
        .xfer_o    (merge_co)
    );

    always_comb begin
        res_o.hi = sum_bit;
        res_o.lo = merge_ci;
    end
endmodule

// File: rtl/rcsa_adder.sv
module rcsa_adder
    import rcsa_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [DIGIT_BITS*N-1:0]                a_i,
    input  logic [DIGIT_BITS*N-1:0]                b_i,
    output logic [DIGIT_BITS*(N+GUARD_DIGITS)-1:0] sum_o
);
    localparam int M = N + GUARD_DIGITS;

    rdigit_t    a_d [M];
    rdigit_t    b_d [M];
    rdigit_t    r_d [M];
    logic [M:0] fold_c;
    logic [M:0] merge_c;
    logic [1:0] unused_top_carries;

    assign fold_c[0]          = 1'b0;
    assign merge_c[0]         = 1'b0;
    assign unused_top_carries = {fold_c[M], merge_c[M]};

    for (genvar k = 0; k < M; k++) begin : g_digit
        if (k < N) begin : g_live
            assign a_d[k] = a_i[DIGIT_BITS*k +: DIGIT_BITS];
            assign b_d[k] = b_i[DIGIT_BITS*k +: DIGIT_BITS];
        end else begin : g_guard
            assign a_d[k] = '0;
            assign b_d[k] = '0;
        end

        rcsa_cell u_cell (
            .a_dig    (a_d[k]),
            .b_dig    (b_d[k]),
            .fold_ci  (fold_c[k]),
            .merge_ci (merge_c[k]),
            .fold_co  (fold_c[k+1]),
            .merge_co (merge_c[k+1]),
            .res_o    (r_d[k])
        );

        assign sum_o[DIGIT_BITS*k +: DIGIT_BITS] = r_d[k];
    end
endmodule

// File: rtl/rcsa_adder_chk.sv
module rcsa_adder_chk #(
    parameter int N = 8
) (
    input logic [2*N-1:0]     a_i,
    input logic [2*N-1:0]     b_i,
    input logic [2*(N+2)-1:0] sum_o
);
    logic [N+3:0] a_val, b_val, s_val;

    always_comb begin
        a_val = '0;
        b_val = '0;
        s_val = '0;
        for (int k = 0; k < N; k++) begin
            a_val = a_val + ((N+4)'(a_i[2*k]) << k) + ((N+4)'(a_i[2*k+1]) << k);
            b_val = b_val + ((N+4)'(b_i[2*k]) << k) + ((N+4)'(b_i[2*k+1]) << k);
        end
        for (int k = 0; k < N+2; k++) begin
            s_val = s_val + ((N+4)'(sum_o[2*k]) << k) + ((N+4)'(sum_o[2*k+1]) << k);
        end
    end

    always_comb begin
        // R2: value of sum equals value of a plus value of b
        assert_value_match_R2: assert (s_val == a_val + b_val);
        // R3: guard digit at the top stays 00
        assert_top_digit_zero_R3: assert (sum_o[2*(N+2)-1 -: 2] == 2'b00);
        // R4: lowest result digit depends only on digit 0 of the operands
        assert_low_digit_local_R4: assert (!(sum_o[1] && sum_o[0]) &&
            ((sum_o[1] ^ sum_o[0]) == (a_i[1] ^ a_i[0] ^ b_i[1] ^ b_i[0])));
        // R6: zero in gives zero out
        assert_zero_in_zero_out_R6: assert (!(a_i == '0 && b_i == '0) || sum_o == '0);
    end
endmodule

bind rcsa_adder rcsa_adder_chk #(.N(N)) u_chk (
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum_o)
);

// File: tb/rcsa_adder_bench.sv
module rcsa_adder_bench;
    localparam int N  = 8;
    localparam int AW = 2*N;
    localparam int SW = 2*(N+2);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [AW-1:0] a, b;
    logic [SW-1:0] s;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    rcsa_adder #(.N(N)) u_rcsa_adder (.a_i(a), .b_i(b), .sum_o(s));

    function automatic longint val_of(input logic [SW-1:0] v, input int digits);
        longint acc = 0;
        for (int k = 0; k < digits; k++)
            acc += longint'(v[2*k] + v[2*k+1]) << k;
        return acc;
    endfunction

    task automatic apply(input logic [AW-1:0] av, input logic [AW-1:0] bv);
        @(posedge clk);
        a = av;
        b = bv;
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_sum(input string req);
        longint exp = val_of(SW'(a), N) + val_of(SW'(b), N);
        check(val_of(s, N+2) == exp, req, val_of(s, N+2), exp);
        check(s[SW-1 -: 2] == 2'b00, "R3", longint'(s[SW-1 -: 2]), 0);
    endtask

    task automatic t_zero();
        apply('0, '0);
        check(s == '0, "R6", longint'(s), 0);
        check_sum("R2");
    endtask

    task automatic t_all_two();
        apply('1, '1);
        check(val_of(s, N+2) == (longint'(1) << (N+2)) - 4, "R5",
              val_of(s, N+2), (longint'(1) << (N+2)) - 4);
        check_sum("R2");
    endtask

    task automatic t_one_codes();
        logic [SW-1:0] ref_s;
        logic [AW-1:0] lo_code, hi_code, mixed;
        for (int k = 0; k < N; k++) begin
            lo_code[2*k +: 2] = 2'b01;
            hi_code[2*k +: 2] = 2'b10;
            mixed[2*k +: 2]   = k[0] ? 2'b10 : 2'b01;
        end
        apply(lo_code, 16'h9c35);
        ref_s = s;
        check_sum("R1");
        apply(hi_code, 16'h9c35);
        check(val_of(s, N+2) == val_of(ref_s, N+2), "R1", val_of(s, N+2), val_of(ref_s, N+2));
        apply(16'h9c35, mixed);
        check(val_of(s, N+2) == val_of(ref_s, N+2), "R1", val_of(s, N+2), val_of(ref_s, N+2));
        apply(lo_code, hi_code);
        check_sum("R1");
    endtask

    task automatic t_random();
        for (int i = 0; i < 60; i++) begin
            apply(AW'($urandom), AW'($urandom));
            check_sum("R2");
        end
    endtask

    task automatic t_locality();
        logic [SW-1:0] base;
        for (int j = 0; j < N; j++) begin
            logic [AW-1:0] av = AW'($urandom);
            logic [AW-1:0] bv = AW'($urandom);
            bit ok = 1;
            apply(av, bv);
            base = s;
            av[2*j +: 2] = (av[2*j +: 2] == 2'b11) ? 2'b00 : 2'b11;
            apply(av, bv);
            for (int k = 0; k < N+2; k++)
                if ((k < j || k > j+2) && s[2*k +: 2] != base[2*k +: 2]) ok = 0;
            check(ok, "R4", longint'(s), longint'(base));
            check_sum("R2");
        end
    endtask

    initial begin
        a = '0;
        b = '0;
        repeat (2) @(posedge clk);
        t_zero();
        t_all_two();
        t_one_codes();
        t_random();
        t_locality();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule